// File: doc/BRIEF.md
# Sixteen-Pin General-Purpose I/O Port

This block is a sixteen-pin digital I/O port that sits on a small register bus. The bus has an address, write data, a write strobe, a read strobe and read data. Each pin has a two-bit mode field, and the port keeps an output data register that drives the pin levels. Software can load the output register whole. It can also change chosen pins through a write-only word: the low half of that word raises pins and the high half lowers them. This avoids any read-modify-write sequence.

The port sits behind a clock-enable register in the same address space. Until its enable bit is set, the port's registers cannot be reached. The port stays unusable for a settling window after the enable is written: an access in the bus cycle directly after the enabling write is dropped, and the cycle after that works. The block drives a level and an output-enable for each pin, samples the pin inputs, and reports which pins are in alternate mode on a status output.

Address map (byte offsets on `addr`): clock enable at 0x14; pin mode at 0x40; sampled inputs at 0x44; output data at 0x48; set/clear word at 0x4C. Reads are registered, so `rdata` carries the addressed value in the cycle after `rd` is high. `rdata` then holds that value until the next read.

Top module: `gpio_port`

## Requirements
- R1: After reset, the clock-enable register reads 0x00000014 and the mode register holds 0xA8000000. This puts pins 13, 14 and 15 in alternate mode, so `alt_mode` is 0xE000. The output data is zero, and `pin_oe` is zero.
- R2: While bit 17 of the clock-enable register is 0, writes to the mode, output data and set/clear registers are discarded, and reads of any port register return zero.
- R3: An access to a port register in the cycle directly after the write that sets bit 17 has no effect, and a read there returns zero. An access one cycle later takes effect.
- R4: A write to the set/clear word with bit n = 1 (n from 0 to 15) drives `pin_out[n]` high. A 1 in bit 16+n drives it low. Pins whose two bits are both 0 keep their level. The new levels appear on `pin_out` in the cycle after the write.
- R5: When one set/clear write has both bit n and bit 16+n at 1, pin n ends high.
- R6: Pin n uses mode bits [2n+1:2n]. The codes are 00 input, 01 output and 10 alternate. `pin_oe[n]` is 1 exactly when the code is 01, and the mode register reads back what was written.
- R7: `alt_mode[n]` is 1 exactly when pin n's mode code is 10, and it is never 1 at the same time as `pin_oe[n]`.
- R8: A read of the set/clear word returns zero. A read of the output data register returns the current output levels in bits 15:0.
- R9: A read of the input register returns the `pin_in` levels that have been stable for at least two cycles.
- R10: A read presents its data on `rdata` in the cycle after `rd` is sampled high.
- R11: A write of the output data register loads bits 15:0 directly onto `pin_out`. `pin_out` changes only after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Register byte offset |
| wdata | input | 32 | Write data |
| wr | input | 1 | Write strobe, one cycle per write |
| rd | input | 1 | Read strobe, one cycle per read |
| rdata | output | 32 | Registered read data |
| pin_in | input | 16 | Pin input levels |
| pin_out | output | 16 | Pin output levels |
| pin_oe | output | 16 | Per-pin output enable |
| alt_mode | output | 16 | Pins currently in alternate mode |

## Verification
The assertions assume that `wr` and `rd` are never high in the same cycle. They also assume that `wdata` and `addr` are stable at every clock edge, and that `pin_in` changes only in cycles with no read of the input register. The stimulus drives every strobe and address on the falling edge and issues one operation per cycle. It holds `pin_in` steady for several idle cycles before reading it. The settling case is covered by placing a port write in the cycle directly after the enabling write.

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int PINS = 16,
  parameter int AW = 8,
  parameter int DW = 32,
  parameter int SETTLE = 1,
  parameter int EN_BIT = 17,
  parameter logic [31:0] CLKEN_RST = 32'h0000_0014,
  parameter logic [31:0] MODE_RST = 32'hA800_0000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  input  logic            wr,
  input  logic            rd,
  output logic [DW-1:0]   rdata,
  input  logic [PINS-1:0] pin_in,
  output logic [PINS-1:0] pin_out,
  output logic [PINS-1:0] pin_oe,
  output logic [PINS-1:0] alt_mode
);
  localparam int CW = $clog2(SETTLE + 1);
  localparam logic [AW-1:0] A_CLKEN = AW'(8'h14);
  localparam logic [AW-1:0] A_MODE  = AW'(8'h40);
  localparam logic [AW-1:0] A_IN    = AW'(8'h44);
  localparam logic [AW-1:0] A_ODR   = AW'(8'h48);
  localparam logic [AW-1:0] A_BSR   = AW'(8'h4C);

  logic [DW-1:0]     clken_q;
  logic [2*PINS-1:0] mode_q;
  logic [PINS-1:0]   odr_q, in_q;
  logic [CW-1:0]     settle_q;
  logic [DW-1:0]     rmux;

  wire en      = clken_q[EN_BIT];
  wire ready   = en && (settle_q == CW'(SETTLE));
  wire port_wr = wr && ready;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) clken_q <= CLKEN_RST[DW-1:0];
    else if (wr && addr == A_CLKEN) clken_q <= wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) settle_q <= '0;
    else if (!en) settle_q <= '0;
    else if (settle_q != CW'(SETTLE)) settle_q <= settle_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) mode_q <= MODE_RST[2*PINS-1:0];
    else if (port_wr && addr == A_MODE) mode_q <= wdata[2*PINS-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) odr_q <= '0;
    else if (port_wr && addr == A_ODR) odr_q <= wdata[PINS-1:0];
    else if (port_wr && addr == A_BSR)
      odr_q <= (odr_q & ~wdata[2*PINS-1:PINS]) | wdata[PINS-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) in_q <= '0;
    else in_q <= pin_in;

  always_comb begin
    rmux = '0;
    if (addr == A_CLKEN) rmux = clken_q;
    else if (ready) begin
      case (addr)
        A_MODE: rmux[2*PINS-1:0] = mode_q;
        A_IN:   rmux[PINS-1:0] = in_q;
        A_ODR:  rmux[PINS-1:0] = odr_q;
        default: rmux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rdata <= '0;
    else if (rd) rdata <= rmux;

  assign pin_out = odr_q;

  for (genvar n = 0; n < PINS; n++) begin : g_pin
    assign pin_oe[n]   = mode_q[2*n +: 2] == 2'b01;
    assign alt_mode[n] = mode_q[2*n +: 2] == 2'b10;
  end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  addr,
  input logic [31:0] wdata,
  input logic        wr,
  input logic        rd,
  input logic [31:0] rdata,
  input logic [15:0] pin_out,
  input logic [15:0] pin_oe,
  input logic [15:0] alt_mode,
  input logic        en,
  input logic        ready
);
  wire port_addr = addr == 8'h40 || addr == 8'h44 || addr == 8'h48 || addr == 8'h4C;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && ready && addr == 8'h4C) |=> ((pin_out & $past(wdata[15:0])) == $past(wdata[15:0]))); // R5

  AST_CLEAR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && ready && addr == 8'h4C) |=>
      ((pin_out & $past(wdata[31:16]) & ~$past(wdata[15:0])) == 16'h0)); // R4

  AST_BLOCKED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !ready && port_addr) |=> ($stable(pin_out) && $stable(pin_oe))); // R2

  AST_BLOCKED_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !ready && port_addr) |=> (rdata == 32'h0)); // R2

  AST_SETTLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == 8'h14 && wdata[17] && !en) |=> !ready); // R3

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(pin_out)); // R11

  AST_MODE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    (alt_mode & pin_oe) == 16'h0); // R7
endmodule

bind gpio_port gpio_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr(wr), .rd(rd),
  .rdata(rdata), .pin_out(pin_out), .pin_oe(pin_oe), .alt_mode(alt_mode),
  .en(en), .ready(ready)
);

// File: tb/gpio_port_test.sv
module gpio_port_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [31:0] rdata;
  logic [15:0] pin_in = '0;
  logic [15:0] pin_out, pin_oe, alt_mode;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  gpio_port uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr(wr), .rd(rd),
    .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .alt_mode(alt_mode)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    addr = a; rd = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: R10 data appears in the cycle after rd
  initial forever begin
    @(posedge clk);
    if (rd && rst_n) begin
      @(negedge clk);
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R10: unexpected read, actual=%h expected=none", rdata);
      end else check(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    idle(2);
    rst_n = 1'b1;
    idle(1);
    check("R1 oe", pin_oe, 32'h0);
    check("R1 alt", alt_mode, 32'hE000);
    check("R1 out", pin_out, 32'h0);
    bus_rd(8'h14, 32'h0000_0014, "R1 clken");

    bus_wr(8'h40, 32'h0000_5555);
    bus_wr(8'h48, 32'h0000_FFFF);
    check("R2 out while disabled", pin_out, 32'h0);
    bus_rd(8'h40, 32'h0, "R2 read while disabled");
    idle(2);

    bus_wr(8'h14, 32'h0002_0014);
    bus_wr(8'h40, 32'h0000_0005);
    idle(1);
    bus_rd(8'h40, 32'hA800_0000, "R3 write right after enable ignored");
    bus_wr(8'h14, 32'h0000_0014);
    idle(1);
    bus_wr(8'h14, 32'h0002_0014);
    bus_rd(8'h48, 32'h0, "R3 read right after enable");
    bus_rd(8'h14, 32'h0002_0014, "R3 clken readback");

    bus_wr(8'h40, 32'hA800_5555);
    bus_rd(8'h40, 32'hA800_5555, "R6 mode readback");
    check("R6 oe pins 0-7", pin_oe, 32'h00FF);
    check("R7 alt pins 13-15", alt_mode, 32'hE000);

    bus_wr(8'h4C, 32'h0000_00A5);
    check("R4 set", pin_out, 32'h00A5);
    bus_rd(8'h4C, 32'h0, "R8 set/clear reads zero");
    bus_rd(8'h48, 32'h0000_00A5, "R8 output readback");
    bus_wr(8'h4C, 32'h0081_0002);
    check("R4 mixed set/clear", pin_out, 32'h0026);
    bus_wr(8'h4C, 32'h0018_0018);
    check("R5 set wins", pin_out, 32'h003E);
    bus_wr(8'h4C, 32'h0000_0000);
    check("R4 zero word unchanged", pin_out, 32'h003E);

    bus_wr(8'h48, 32'hFFFF_1234);
    check("R11 direct load", pin_out, 32'h1234);

    bus_wr(8'h40, 32'h0000_0002);
    check("R7 pin0 alt", alt_mode, 32'h0001);
    check("R6 no outputs", pin_oe, 32'h0);
    bus_wr(8'h40, 32'h4000_0000);
    check("R6 pin15 field", pin_oe, 32'h8000);
    check("R7 none alt", alt_mode, 32'h0);

    pin_in = 16'hBEEF;
    idle(3);
    bus_rd(8'h44, 32'h0000_BEEF, "R9 input sample");
    pin_in = 16'h0F0F;
    idle(3);
    bus_rd(8'h44, 32'h0000_0F0F, "R9 input sample 2");

    bus_wr(8'h14, 32'h0000_0014);
    bus_wr(8'h48, 32'h0000_FFFF);
    bus_wr(8'h4C, 32'hFFFF_0000);
    check("R2 out kept while disabled", pin_out, 32'h1234);
    bus_rd(8'h48, 32'h0, "R2 read zero while disabled");
    bus_wr(8'h14, 32'h0002_0014);
    idle(1);
    bus_rd(8'h48, 32'h0000_1234, "R2 writes discarded");

    idle(3);
    finish_run();
  end
endmodule